// File: doc/BRIEF.md
# Voice Key-On/Key-Off Controller

This block holds the note-gating registers of an eight-voice sample synthesiser. A host writes single bytes through an address/data pair. The block keeps four registers: key-on, key-off, end-flag and a flag register. It sends one-cycle start and release pulse vectors to the voice engines, with one bit per voice. The voice engines report the end of a sample through an input vector that sets end-flag bits.

A key-on request for a voice whose key-off bit is set does not start the voice. The request is held as pending. It fires only when a later key-off write leaves that voice's bit clear. Setting bit 7 of the flag register performs a soft reset: the note state is cleared and every voice is released.

Register offsets are: key-on 0x10, key-off 0x11, flag 0x12, end-flag 0x13. In the flag register, bit 7 is soft reset, bit 6 is mute and bit 5 is echo-off.

Top module: `voice_key_ctrl`

## Requirements
- R1: After reset, the flag register reads 0x60 (mute and echo-off set). The key-on, key-off and end-flag registers read 0x00, and both pulse vectors are 0.
- R2: A key-on write (0x10) starts each voice n whose data bit n is set and whose key-off bit n is clear. It clears that voice's end-flag bit. The key-on register stores the written byte.
- R3: A key-on write does not start a voice n whose key-off bit n is set. The request is held as pending for that voice.
- R4: A key-off write (0x11) stores its data. Each set bit releases voice n only if that voice is keyed, and clears key-on bit n for each voice it releases. A set bit for an idle voice produces no release pulse.
- R5: On a key-off write, each clear bit n whose voice has a pending key-on starts voice n, clears its end-flag bit and drops the pending request. A later key-off write then produces no second start.
- R6: A flag write (0x12) with bit 7 set stores 0x60 ORed with data bits 4..0. It clears the end-flag, key-off and key-on registers, cancels pending and keyed state, and pulses release on all eight voices.
- R7: A flag write with bit 7 clear stores the data byte unchanged.
- R8: A write to the end-flag register (0x13) stores zero, whatever the data.
- R9: Bits of the end-set input are ORed into the end-flag register. A start of the same voice in the same cycle clears the bit instead.
- R10: Writes to addresses 0x80 and above have no effect. Reads use only address bits 6..0. Addresses that are not mapped read 0x00.
- R11: The start and release vectors are registered. They are asserted only in the cycle after the write that caused them, and for one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write register address |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | 8 | Read register address (bit 7 ignored) |
| rd_data | output | 8 | Combinational read data |
| end_set | input | 8 | End-of-sample flags from the voice engines |
| voice_start | output | 8 | Start pulse, one bit per voice |
| voice_release | output | 8 | Release pulse, one bit per voice |

## Verification
The assertions assume that wr_en, wr_addr, wr_data and end_set are steady around each rising edge and have known values whenever reset is deasserted. The bench meets this by driving every input on the falling edge only. It holds the write strobe for exactly one clock and keeps end_set at zero except in the tests that target R9. The bench never depends on a key-off that arrives in the same cycle as a key-on, because writes are serialized through the single port.

// File: rtl/vkc_pkg.sv
package vkc_pkg;
  localparam int VOICES = 8;
  localparam int DW     = 8;
  typedef logic [VOICES-1:0] vmask_t;

  localparam logic [6:0] ADDR_KEYON  = 7'h10;
  localparam logic [6:0] ADDR_KEYOFF = 7'h11;
  localparam logic [6:0] ADDR_FLAG   = 7'h12;
  localparam logic [6:0] ADDR_ENDF   = 7'h13;

  localparam int BIT_SOFT = 7;
  localparam logic [DW-1:0] FLAG_MUTE    = 8'h40;
  localparam logic [DW-1:0] FLAG_ECHOOFF = 8'h20;
  localparam logic [DW-1:0] FLAG_RESET   = FLAG_MUTE | FLAG_ECHOOFF;

  // voices a key-on write starts immediately
  function automatic vmask_t keyon_go(input vmask_t d, input vmask_t koff);
    return d & ~koff;
  endfunction

  // voices a key-on write defers
  function automatic vmask_t keyon_hold(input vmask_t d, input vmask_t koff);
    return d & koff;
  endfunction

  // voices a key-off write releases
  function automatic vmask_t keyoff_cut(input vmask_t d, input vmask_t keyed);
    return d & keyed;
  endfunction

  // deferred voices a key-off write lets through
  function automatic vmask_t keyoff_fire(input vmask_t d, input vmask_t pend);
    return ~d & pend;
  endfunction

  function automatic logic [DW-1:0] soft_flag(input logic [DW-1:0] d);
    return FLAG_RESET | {3'b000, d[4:0]};
  endfunction
endpackage

// File: rtl/vkc_decode.sv
module vkc_decode
  import vkc_pkg::*;
(
  input  logic          wr_en,
  input  logic [7:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          wr_keyon,
  output logic          wr_keyoff,
  output logic          wr_flag,
  output logic          wr_endf,
  output logic          soft_rst
);
  logic in_range;
  assign in_range  = wr_en && !wr_addr[7];
  assign wr_keyon  = in_range && (wr_addr[6:0] == ADDR_KEYON);
  assign wr_keyoff = in_range && (wr_addr[6:0] == ADDR_KEYOFF);
  assign wr_flag   = in_range && (wr_addr[6:0] == ADDR_FLAG);
  assign wr_endf   = in_range && (wr_addr[6:0] == ADDR_ENDF);
  assign soft_rst  = wr_flag && wr_data[BIT_SOFT];

  always_comb begin
    a_r10_onehot_decode: assert ($onehot0({wr_keyon, wr_keyoff, wr_flag, wr_endf}));
  end
endmodule

// File: rtl/vkc_key_logic.sv
module vkc_key_logic
  import vkc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_keyon,
  input  logic   wr_keyoff,
  input  logic   soft_rst,
  input  vmask_t wr_mask,
  output vmask_t start_ev,
  output vmask_t keyon_q,
  output vmask_t keyoff_q,
  output vmask_t start_q,
  output vmask_t release_q
);
  vmask_t pend_q, keyed_q, rel_ev;

  always_comb begin
    start_ev = '0;
    rel_ev   = '0;
    if (soft_rst)       rel_ev   = '1;
    else if (wr_keyon)  start_ev = keyon_go(wr_mask, keyoff_q);
    else if (wr_keyoff) begin
      start_ev = keyoff_fire(wr_mask, pend_q);
      rel_ev   = keyoff_cut(wr_mask, keyed_q);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      keyon_q   <= '0;
      keyoff_q  <= '0;
      pend_q    <= '0;
      keyed_q   <= '0;
      start_q   <= '0;
      release_q <= '0;
    end else begin
      start_q   <= start_ev;
      release_q <= rel_ev;
      if (soft_rst) begin
        keyon_q  <= '0;
        keyoff_q <= '0;
        pend_q   <= '0;
        keyed_q  <= '0;
      end else if (wr_keyon) begin
        keyon_q <= wr_mask;
        pend_q  <= pend_q | keyon_hold(wr_mask, keyoff_q);
        keyed_q <= keyed_q | start_ev;
      end else if (wr_keyoff) begin
        keyoff_q <= wr_mask;
        keyon_q  <= keyon_q & ~rel_ev;
        pend_q   <= pend_q & ~(rel_ev | start_ev);
        keyed_q  <= (keyed_q & ~rel_ev) | start_ev;
      end
    end
  end

  a_r3_no_start_while_off: assert property (@(posedge clk) disable iff (!rst_n)
    wr_keyon |=> (start_q & $past(keyoff_q)) == '0);
  a_r4_release_only_keyed: assert property (@(posedge clk) disable iff (!rst_n)
    wr_keyoff |=> (release_q & ~$past(keyed_q)) == '0);
  a_r5_fire_only_pending: assert property (@(posedge clk) disable iff (!rst_n)
    wr_keyoff |=> (start_q & ~$past(pend_q)) == '0);
  a_r6_soft_releases_all: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> release_q == '1 && keyoff_q == '0 && keyon_q == '0);
  a_r11_pulse_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_keyon || wr_keyoff || soft_rst) |=> start_q == '0 && release_q == '0);
endmodule

// File: rtl/vkc_flag_regs.sv
module vkc_flag_regs
  import vkc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_flag,
  input  logic          wr_endf,
  input  logic          soft_rst,
  input  logic [DW-1:0] wr_data,
  input  vmask_t        end_set,
  input  vmask_t        start_ev,
  output logic [DW-1:0] flag_q,
  output vmask_t        endf_q
);
  vmask_t endf_base;
  assign endf_base = (wr_endf || soft_rst) ? '0 : endf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= FLAG_RESET;
      endf_q <= '0;
    end else begin
      if (soft_rst)     flag_q <= soft_flag(wr_data);
      else if (wr_flag) flag_q <= wr_data;
      endf_q <= (endf_base | end_set) & ~start_ev;
    end
  end

  a_r9_start_clears_end: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev != '0 |=> (endf_q & $past(start_ev)) == '0);
  a_r6_soft_keeps_mute: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (flag_q & FLAG_RESET) == FLAG_RESET);
  a_r9_end_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (end_set != '0 && start_ev == '0) |=> (endf_q & $past(end_set)) == $past(end_set));
endmodule

// File: rtl/voice_key_ctrl.sv
module voice_key_ctrl
  import vkc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [7:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic [7:0] end_set,
  output logic [7:0] voice_start,
  output logic [7:0] voice_release
);
  logic wr_keyon, wr_keyoff, wr_flag, wr_endf, soft_rst;
  vmask_t start_ev, keyon_q, keyoff_q, endf_q;
  logic [DW-1:0] flag_q;

  vkc_decode u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_keyon(wr_keyon), .wr_keyoff(wr_keyoff), .wr_flag(wr_flag),
    .wr_endf(wr_endf), .soft_rst(soft_rst)
  );

  vkc_key_logic u_key (
    .clk(clk), .rst_n(rst_n), .wr_keyon(wr_keyon), .wr_keyoff(wr_keyoff),
    .soft_rst(soft_rst), .wr_mask(wr_data), .start_ev(start_ev),
    .keyon_q(keyon_q), .keyoff_q(keyoff_q),
    .start_q(voice_start), .release_q(voice_release)
  );

  vkc_flag_regs u_flg (
    .clk(clk), .rst_n(rst_n), .wr_flag(wr_flag), .wr_endf(wr_endf),
    .soft_rst(soft_rst), .wr_data(wr_data), .end_set(end_set),
    .start_ev(start_ev), .flag_q(flag_q), .endf_q(endf_q)
  );

  always_comb begin
    case (rd_addr[6:0])
      ADDR_KEYON:  rd_data = keyon_q;
      ADDR_KEYOFF: rd_data = keyoff_q;
      ADDR_FLAG:   rd_data = flag_q;
      ADDR_ENDF:   rd_data = endf_q;
      default:     rd_data = '0;
    endcase
  end

  a_r11_no_start_release_same_voice: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (voice_start & voice_release) == '0 || voice_release == '1);
endmodule

// File: tb/voice_key_ctrl_test.sv
module voice_key_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_ON = 8'h10, A_OFF = 8'h11, A_FLG = 8'h12, A_END = 8'h13;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [7:0] wr_addr = 0, wr_data = 0, rd_addr = 0, end_set = 0;
  logic [7:0] rd_data, voice_start, voice_release;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  voice_key_ctrl uut (.*);

  // {addr, data, expected start, expected release, expected key-on readback}
  localparam logic [39:0] VEC [11] = '{
    {A_OFF, 8'h00, 8'h00, 8'h00, 8'h00},
    {A_ON,  8'h03, 8'h03, 8'h00, 8'h03},
    {A_OFF, 8'h01, 8'h00, 8'h01, 8'h02},
    {A_ON,  8'h05, 8'h04, 8'h00, 8'h05},
    {A_OFF, 8'h08, 8'h01, 8'h00, 8'h05},
    {A_OFF, 8'h00, 8'h00, 8'h00, 8'h05},
    {A_ON,  8'hF0, 8'hF0, 8'h00, 8'hF0},
    {A_OFF, 8'hFF, 8'h00, 8'hF7, 8'h00},
    {A_ON,  8'h81, 8'h00, 8'h00, 8'h81},
    {A_OFF, 8'h80, 8'h01, 8'h00, 8'h81},
    {A_OFF, 8'h00, 8'h80, 8'h00, 8'h81}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  // one-cycle write; returns with outputs of the cycle after the write visible
  task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic [7:0] es = 8'h00);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d; end_set = es;
    @(negedge clk);
    wr_en = 0; end_set = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    rd_addr = a; #1; v = rd_data;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(A_FLG, v); chk("R1 flag", v, 8'h60);
    rd(A_ON, v);  chk("R1 keyon", v, 8'h00);
    rd(A_OFF, v); chk("R1 keyoff", v, 8'h00);
    rd(A_END, v); chk("R1 endflag", v, 8'h00);
    chk("R1 start", voice_start, 8'h00);
    chk("R1 release", voice_release, 8'h00);

    // R2 R3 R4 R5 table walk
    for (int i = 0; i < 11; i++) begin
      wr(VEC[i][39:32], VEC[i][31:24]);
      chk("R2/R3/R5 start", voice_start, VEC[i][23:16]);
      chk("R4 release", voice_release, VEC[i][15:8]);
      rd(A_ON, v);  chk("R2/R4 keyon readback", v, VEC[i][7:0]);
      if (VEC[i][39:32] == A_OFF) begin
        rd(A_OFF, v); chk("R4 keyoff readback", v, VEC[i][31:24]);
      end
    end

    // R11 pulse lasts one cycle
    wr(A_ON, 8'h02);
    chk("R11 start in cycle after write", voice_start, 8'h02);
    @(negedge clk);
    chk("R11 start gone", voice_start, 8'h00);
    chk("R11 release gone", voice_release, 8'h00);

    // R9 end-set merge and start priority
    wr(A_END, 8'h00);
    @(negedge clk); end_set = 8'h0C; @(negedge clk); end_set = 8'h00;
    rd(A_END, v); chk("R9 end_set ORed", v, 8'h0C);
    wr(A_ON, 8'h04, 8'h04);
    rd(A_END, v); chk("R9 start beats end_set", v, 8'h08);
    // R2 start clears end flag
    @(negedge clk); end_set = 8'h10; @(negedge clk); end_set = 8'h00;
    wr(A_ON, 8'h10);
    rd(A_END, v); chk("R2 end flag cleared by start", v, 8'h08);

    // R8 end-flag write stores zero
    wr(A_END, 8'h5A);
    rd(A_END, v); chk("R8 endflag write zero", v, 8'h00);

    // R10 upper addresses ignored, read masking, unmapped reads
    wr(A_OFF, 8'h40);
    rd(8'h91, v); chk("R10 read masks bit7", v, 8'h40);
    wr(8'h91, 8'h00);
    chk("R10 high write no start", voice_start, 8'h00);
    rd(A_OFF, v); chk("R10 high write ignored", v, 8'h40);
    wr(8'h92, 8'h80);
    chk("R10 high flag write no release", voice_release, 8'h00);
    rd(A_FLG, v); chk("R10 high flag write ignored", v, 8'h60);
    rd(8'h20, v); chk("R10 unmapped reads zero", v, 8'h00);

    // R7 plain flag write
    wr(A_FLG, 8'h1F);
    rd(A_FLG, v); chk("R7 flag stored", v, 8'h1F);

    // R6 soft reset
    wr(A_OFF, 8'h02);
    wr(A_ON, 8'h02);
    chk("R3 deferred no start", voice_start, 8'h00);
    @(negedge clk); end_set = 8'h30; @(negedge clk); end_set = 8'h00;
    wr(A_FLG, 8'h83);
    chk("R6 release all", voice_release, 8'hFF);
    chk("R6 no start", voice_start, 8'h00);
    rd(A_FLG, v); chk("R6 flag value", v, 8'h63);
    rd(A_END, v); chk("R6 endflag cleared", v, 8'h00);
    rd(A_OFF, v); chk("R6 keyoff cleared", v, 8'h00);
    rd(A_ON, v);  chk("R6 keyon cleared", v, 8'h00);
    wr(A_OFF, 8'h00);
    chk("R6 pending cancelled", voice_start, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule